// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides whether an instruction carrying a 4-bit condition field may execute, given the current negative (N), zero (Z), carry (C) and overflow (V) flags. The decision is a pure function of the code and the four flags. The same block also derives the signed-overflow flag for an addition and for a subtraction. It does this from the sign bits of the two operands and of the result that the datapath produced.

The combinational evaluators sit behind a single register stage with a valid strobe. A result appears one cycle after an accepted input and stays on the outputs until the next accepted input. This lets the unit drop into a pipelined decode path. Every condition code executes on some flag value. The all-ones code is an unconditional pass, reserved for extension encodings, and is never a "never execute" code.

Top module: `cond_gate`

## Requirements
- R1: Flag inputs are packed as in_flags[3]=N, [2]=Z, [1]=C, [0]=V. Codes 0 to 7 test a single flag: 0 passes on Z=1, 1 on Z=0, 2 on C=1, 3 on C=0, 4 on N=1, 5 on N=0, 6 on V=1, 7 on V=0.
- R2: Code 8 passes when C=1 and Z=0; code 9 passes when C=0 or Z=1.
- R3: Code 10 passes when N equals V; code 11 passes when N differs from V.
- R4: Code 12 passes when Z=0 and N equals V; code 13 passes when Z=1 or N differs from V.
- R5: Codes 14 and 15 pass for every flag combination.
- R6: out_add_ovf is set exactly when the sign bits of op_a and op_b agree and the sign bit of op_r differs from that of op_a. This means op_r=op_a+op_b overflowed as a signed sum.
- R7: out_sub_ovf is set exactly when the sign bits of op_a and op_b differ and the sign bit of op_r differs from that of op_a. This means op_r=op_a-op_b overflowed as a signed difference.
- R8: When in_valid is high at a rising edge, out_valid is high for the following cycle and carries that input's results. When in_valid is low at an edge, out_valid goes low and out_pass, out_add_ovf and out_sub_ovf keep their values.
- R9: A synchronous active-high reset clears out_valid, out_pass, out_add_ovf and out_sub_ovf to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; inputs are captured when high |
| in_code | input | 4 | Condition field |
| in_flags | input | 4 | {N, Z, C, V} |
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| op_r | input | DATA_W | Result produced from op_a and op_b |
| out_valid | output | 1 | High for one cycle after an accepted input |
| out_pass | output | 1 | Instruction may execute |
| out_add_ovf | output | 1 | Signed overflow, treating op_r as a sum |
| out_sub_ovf | output | 1 | Signed overflow, treating op_r as a difference |

## Verification
The assertions assume that every input is driven to a known value whenever in_valid is high. They also assume that reset is held for at least one edge before the first accepted input. The bench changes inputs only on falling edges and keeps in_valid at 0 or 1 at all times. It sweeps every pairing of the 16 codes with the 16 flag values. It then feeds operand triples in which op_r is the true wrapped sum or difference, covering the signed boundary values where overflow flips.

// File: rtl/cond_gate_pkg.sv
package cond_gate_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Upper three bits of the condition field select a test; bit 0 inverts it.
  typedef enum logic [2:0] {
    GRP_ZERO   = 3'd0,
    GRP_CARRY  = 3'd1,
    GRP_NEG    = 3'd2,
    GRP_OVF    = 3'd3,
    GRP_HIGHER = 3'd4,
    GRP_SGE    = 3'd5,
    GRP_SGT    = 3'd6,
    GRP_ALWAYS = 3'd7
  } cond_grp_t;
endpackage

// File: rtl/cond_test.sv
module cond_test
  import cond_gate_pkg::*;
(
  input  logic [3:0] code,
  input  flags_t     flags,
  output logic       pass
);
  cond_grp_t grp;
  logic      base;

  always_comb begin
    grp = cond_grp_t'(code[3:1]);
    unique case (grp)
      GRP_ZERO:   base = flags.z;
      GRP_CARRY:  base = flags.c;
      GRP_NEG:    base = flags.n;
      GRP_OVF:    base = flags.v;
      GRP_HIGHER: base = flags.c & ~flags.z;
      GRP_SGE:    base = ~(flags.n ^ flags.v);
      GRP_SGT:    base = ~flags.z & ~(flags.n ^ flags.v);
      default:    base = 1'b1;
    endcase
    // The always group ignores the invert bit so that the all-ones code also passes.
    pass = (grp == GRP_ALWAYS) ? 1'b1 : (base ^ code[0]);
  end
endmodule

// File: rtl/ovf_detect.sv
module ovf_detect #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] r,
  output logic              add_ovf,
  output logic              sub_ovf
);
  localparam int MSB = DATA_W - 1;

  logic sa, sb, sr;
  logic unused_low;

  assign sa = a[MSB];
  assign sb = b[MSB];
  assign sr = r[MSB];

  generate
    if (DATA_W > 1) begin : g_low
      assign unused_low = ^{a[MSB-1:0], b[MSB-1:0], r[MSB-1:0]};
    end else begin : g_nolow
      assign unused_low = 1'b0;
    end
  endgenerate

  // Operands of equal sign for a sum, or opposite sign for a difference,
  // overflow when the result's sign leaves that of the first operand.
  assign add_ovf = ~(sa ^ sb) & (sa ^ sr);
  assign sub_ovf =  (sa ^ sb) & (sa ^ sr);
endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic             vld,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      q   <= '0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/cond_gate.sv
module cond_gate
  import cond_gate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        in_code,
  input  logic [3:0]        in_flags,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] op_r,
  output logic              out_valid,
  output logic              out_pass,
  output logic              out_add_ovf,
  output logic              out_sub_ovf
);
  localparam int RES_W = 3;

  logic             pass_c;
  logic             add_c;
  logic             sub_c;
  logic [RES_W-1:0] res_q;

  cond_test u_test (
    .code  (in_code),
    .flags (flags_t'(in_flags)),
    .pass  (pass_c)
  );

  ovf_detect #(.DATA_W(DATA_W)) u_ovf (
    .a       (op_a),
    .b       (op_b),
    .r       (op_r),
    .add_ovf (add_c),
    .sub_ovf (sub_c)
  );

  result_stage #(.WIDTH(RES_W)) u_stage (
    .clk  (clk),
    .rst  (rst),
    .load (in_valid),
    .d    ({pass_c, add_c, sub_c}),
    .vld  (out_valid),
    .q    (res_q)
  );

  assign {out_pass, out_add_ovf, out_sub_ovf} = res_q;
endmodule

// File: rtl/cond_gate_chk.sv
module cond_gate_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        in_code,
  input logic [3:0]        in_flags,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [DATA_W-1:0] op_r,
  input logic              out_valid,
  input logic              out_pass,
  input logic              out_add_ovf,
  input logic              out_sub_ovf
);
  localparam int MSB = DATA_W - 1;

  a_r1_zero_test: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code == 4'd0) |=> (out_pass == $past(in_flags[2])));

  a_r2_higher_pair: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code == 4'd8 && in_flags[1] && !in_flags[2]) |=> out_pass);

  a_r3_sign_pair: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code == 4'd11 && (in_flags[3] == in_flags[0])) |=> !out_pass);

  a_r5_always_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code[3:1] == 3'b111) |=> out_pass);

  a_r6_add_ovf: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_a[MSB] == op_b[MSB] && op_r[MSB] != op_a[MSB]) |=> out_add_ovf);

  a_r7_sub_mutex: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_add_ovf && out_sub_ovf));

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_pass) && $stable(out_add_ovf) && $stable(out_sub_ovf)));

  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_pass && !out_add_ovf && !out_sub_ovf));
endmodule

bind cond_gate cond_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_code     (in_code),
  .in_flags    (in_flags),
  .op_a        (op_a),
  .op_b        (op_b),
  .op_r        (op_r),
  .out_valid   (out_valid),
  .out_pass    (out_pass),
  .out_add_ovf (out_add_ovf),
  .out_sub_ovf (out_sub_ovf)
);

// File: tb/cond_gate_tb.sv
module cond_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int WATCHDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic [3:0]        in_code;
  logic [3:0]        in_flags;
  logic [DATA_W-1:0] op_a, op_b, op_r;
  logic              out_valid, out_pass, out_add_ovf, out_sub_ovf;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_gate #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .in_flags(in_flags), .op_a(op_a), .op_b(op_b), .op_r(op_r),
    .out_valid(out_valid), .out_pass(out_pass),
    .out_add_ovf(out_add_ovf), .out_sub_ovf(out_sub_ovf)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Expected pass from the requirement text; flags packed {N,Z,C,V}.
  function automatic logic exp_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c < 4'd8)  return "R1";
    if (c < 4'd10) return "R2";
    if (c < 4'd12) return "R3";
    if (c < 4'd14) return "R4";
    return "R5";
  endfunction

  // One accepted transaction; outputs sampled one falling edge later.
  task automatic apply(input logic [3:0] c, input logic [3:0] f,
                       input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                       input logic [DATA_W-1:0] r);
    @(negedge clk);
    in_valid = 1'b1; in_code = c; in_flags = f; op_a = a; op_b = b; op_r = r;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic add_overflows(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    longint s;
    s = longint'($signed(a)) + longint'($signed(b));
    return (s > longint'(2**(DATA_W-1) - 1)) || (s < -longint'(2**(DATA_W-1)));
  endfunction

  function automatic logic sub_overflows(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    longint s;
    s = longint'($signed(a)) - longint'($signed(b));
    return (s > longint'(2**(DATA_W-1) - 1)) || (s < -longint'(2**(DATA_W-1)));
  endfunction

  task automatic ovf_case(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    apply(4'hE, 4'h0, a, b, a + b);
    check("R6 add overflow", out_add_ovf, add_overflows(a, b));
    apply(4'hE, 4'h0, a, b, a - b);
    check("R7 sub overflow", out_sub_ovf, sub_overflows(a, b));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_code = '0; in_flags = '0;
    op_a = '0; op_b = '0; op_r = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 out_valid", out_valid, 1'b0);
    check("R9 out_pass", out_pass, 1'b0);
    check("R9 out_add_ovf", out_add_ovf, 1'b0);
    check("R9 out_sub_ovf", out_sub_ovf, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 idle no valid", out_valid, 1'b0);

    // R1..R5: full sweep of codes against flag values
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        apply(4'(c), 4'(f), '0, '0, '0);
        check(req_of(4'(c)), out_pass, exp_pass(4'(c), 4'(f)));
        check("R8 valid after input", out_valid, 1'b1);
      end
    end

    // R8: hold while in_valid is low, with inputs changed
    apply(4'd0, 4'b0100, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000); // pass=1, add ovf=1
    in_code = 4'd1; in_flags = 4'b0100; op_a = '0; op_b = '0; op_r = '0;
    @(negedge clk);
    @(negedge clk);
    check("R8 hold valid low", out_valid, 1'b0);
    check("R8 hold pass", out_pass, 1'b1);
    check("R8 hold add_ovf", out_add_ovf, 1'b1);
    check("R8 hold sub_ovf", out_sub_ovf, 1'b0);

    // R6, R7: boundary and scattered operands
    ovf_case(32'h7FFF_FFFF, 32'h0000_0001);
    ovf_case(32'h8000_0000, 32'hFFFF_FFFF);
    ovf_case(32'h8000_0000, 32'h0000_0001);
    ovf_case(32'h0000_0000, 32'h8000_0000);
    ovf_case(32'h7FFF_FFFF, 32'hFFFF_FFFF);
    ovf_case(32'h8000_0000, 32'h8000_0000);
    ovf_case(32'h0000_0000, 32'h0000_0000);
    for (int i = 0; i < 24; i++) begin
      ovf_case(32'(i) * 32'h1357_9BDF ^ 32'hA5A5_0000,
               32'(i) * 32'h9E37_79B9 + 32'h4000_0000);
    end

    // R9: reset after activity clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears valid", out_valid, 1'b0);
    check("R9 reset clears pass", out_pass, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule